// File: doc/BRIEF.md
# External Bus Read Sequencer

The block runs read accesses on an external asynchronous memory bus for an internal master. A request from the master latches the address and the timing configuration. The block then drives the address and pulls an active-low chip-select. After a programmable lead phase it pulls an active-low read strobe for a programmable active phase. The two phases are counted in whole bus-clock cycles.

The active phase can be stretched by an external ready pin. A mode input picks how the pin is treated. In synchronous mode the pin is registered once. In asynchronous mode it passes through a two-stage synchronizer, so its sampling starts two cycles earlier.

When the access completes, chip-select and the strobe rise on the same edge and the bus data is captured. A one-cycle done pulse then reports the captured word. Between accesses the address pins keep the last address that was driven.

Top module: `xbus_rd_seq`

## Requirements
- R1: While reset is applied, and after it is released, bus_cs_n and bus_rd_n are 1, busy and done are 0, and bus_addr and rdata are 0.
- R2: The block is idle when busy is 0. A req that is 1 at a clock edge while idle starts an access, and access cycle 1 is the cycle after that edge. In cycle 1, bus_cs_n is 0, bus_rd_n is 1, busy is 1 and bus_addr equals the addr sampled at that edge. lead_cnt, active_cnt and ready_mode are latched at the same edge.
- R3: Let L be the latched lead_cnt. bus_rd_n is 1 in access cycles 1..L and 0 from cycle L+1 until the access completes.
- R4: Synchronous mode is ready_mode=0. Let A be the latched active_cnt. bus_ready is sampled at the edge that ends access cycle L+A, and at every later edge. The access completes at the edge after the first sample that reads 1, so it lasts at least L+A+1 cycles.
- R5: Asynchronous mode is ready_mode=1. bus_ready is sampled at the edge that ends access cycle L+A-2, and at every later edge. The edge that accepted the request counts as the edge ending cycle 0. The access completes two edges after the first sample that reads 1, so it lasts at least L+A cycles.
- R6: On the completing edge, bus_cs_n and bus_rd_n both rise to 1 and rdata takes the bus_data value present at that edge. done is 1 for exactly the one cycle that follows, and busy is 0 in that cycle.
- R7: In all cycles with no access, including the cycle right after a completion, bus_addr holds the last address driven.
- R8: A lead_cnt or active_cnt of 0 is used as a count of 1.
- R9: req and addr are ignored during an access. A request held across a completion is accepted at the edge that ends the idle cycle after the completion, so bus_cs_n is 1 for exactly one cycle between back-to-back accesses.
- R10: rdata keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, sampled while idle |
| addr | input | ADDR_W (16) | Read address |
| ready_mode | input | 1 | 0 = synchronous ready, 1 = asynchronous ready |
| lead_cnt | input | LEAD_W (2) | Lead phase length in cycles (0 means 1) |
| active_cnt | input | ACT_W (3) | Active phase length in cycles (0 means 1) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse, rdata valid |
| rdata | output | DATA_W (16) | Captured read word |
| bus_addr | output | ADDR_W (16) | External address |
| bus_cs_n | output | 1 | External chip-select, active low |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_data | input | DATA_W (16) | External read data |
| bus_ready | input | 1 | External ready pin |

## Verification
An accepted request shows on the bus in the very next cycle. The strobe falls L cycles later. Completion comes one edge after a high ready sample in synchronous mode and two edges after it in asynchronous mode, and done and the captured data follow one cycle after that edge. A behavioural model in the bench keeps a history of the ready pin. It is advanced at each rising edge and compared with every output at the following falling edge, so each result is checked in the cycle it is due. Directed runs measure the chip-select width and the strobe start against closed-form expectations for normal, zero, maximum and stretched counts in both modes.

// File: rtl/xbus_rd_pkg.sv
// Shared types for the external bus read sequencer.
// Assumes: single bus clock domain for the sequencer itself.
package xbus_rd_pkg;
    typedef enum logic {
        RDY_SYNC  = 1'b0,
        RDY_ASYNC = 1'b1
    } rdy_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } seq_state_e;
endpackage

// File: rtl/xbus_rdy_pipe.sv
// Ready input pipeline: a free-running shift register on the ready pin.
// Synchronous mode evaluates the first stage. Asynchronous mode evaluates
// the last stage, which acts as the synchronizer.
// Assumes: SYNC_STAGES >= 2; all stages clear to 0 in reset.
module xbus_rdy_pipe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic async_sel,
    output logic rdy_eval
);
    logic [SYNC_STAGES-1:0] stg;

    // First stage captures the raw pin every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= pin;
    end

    // Remaining stages form the synchronizer chain.
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
        end
    end

    // Mode picks the stage that the sequencer evaluates.
    always_comb rdy_eval = async_sel ? stg[SYNC_STAGES-1] : stg[0];
endmodule

// File: rtl/xbus_phase_ctr.sv
// Phase counter: counts access cycles from 1 and saturates at the latest
// possible first-sample point. It flags the cycle in which the strobe must
// fall and the window in which ready decides completion.
// Assumes: lead_len and act_len are already non-zero.
module xbus_phase_ctr #(
    parameter int LEAD_W = 2,
    parameter int ACT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [LEAD_W-1:0] lead_len,
    input  logic [ACT_W-1:0]  act_len,
    input  logic              async_mode,
    output logic              strobe_now,
    output logic              window
);
    localparam int CMAX = (2**LEAD_W - 1) + (2**ACT_W - 1) + 1;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] cyc;
    logic [CW-1:0] first_pt;

    // Access cycle counter, saturating at CMAX.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cyc <= '0;
        else if (start)                   cyc <= CW'(1);
        else if (run && cyc < CW'(CMAX))  cyc <= cyc + CW'(1);
    end

    // Earliest cycle whose ending edge may complete the access.
    always_comb first_pt = CW'(lead_len) + CW'(act_len) + (async_mode ? CW'(0) : CW'(1));

    // Strobe falls at the edge that ends the last lead cycle.
    always_comb strobe_now = run && (cyc == CW'(lead_len));

    // Ready is evaluated once the first sample point is reached.
    always_comb window = run && (cyc >= first_pt);

    // Once open, the window stays open until the access ends (R4).
    assert_window_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (window && run && !start) |=> (window || !run));

    // The strobe cannot fall in the first cycle of an access (R3).
    assert_no_strobe_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !strobe_now || (lead_len == LEAD_W'(1)));
endmodule

// File: rtl/xbus_rd_seq.sv
// External bus read sequencer top. It accepts a request while idle, drives
// the address and chip-select, lowers the strobe after the lead phase, and
// completes on ready. On completion it captures data and pulses done.
// Assumes: bus_data is stable around the completing edge; the ready pin
// meets setup to the bus clock in synchronous mode.
module xbus_rd_seq
    import xbus_rd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int LEAD_W      = 2,
    parameter int ACT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ready_mode,
    input  logic [LEAD_W-1:0] lead_cnt,
    input  logic [ACT_W-1:0]  active_cnt,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_ready
);
    seq_state_e        state;
    rdy_mode_e         mode_q;
    logic [LEAD_W-1:0] lead_q;
    logic [ACT_W-1:0]  act_q;
    logic [LEAD_W-1:0] lead_eff;
    logic [ACT_W-1:0]  act_eff;
    logic              start;
    logic              run;
    logic              strobe_now;
    logic              window;
    logic              rdy_eval;
    logic              complete;

    // A zero count stands for one cycle (R8).
    always_comb lead_eff = (lead_cnt == '0) ? LEAD_W'(1) : lead_cnt;
    always_comb act_eff  = (active_cnt == '0) ? ACT_W'(1) : active_cnt;

    // Request acceptance and access run flags.
    always_comb start = (state == ST_IDLE) && req;
    always_comb run   = (state == ST_ACCESS);
    always_comb busy  = run;

    xbus_rdy_pipe #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (bus_ready),
        .async_sel (mode_q == RDY_ASYNC),
        .rdy_eval  (rdy_eval)
    );

    xbus_phase_ctr #(
        .LEAD_W (LEAD_W),
        .ACT_W  (ACT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (run),
        .lead_len   (lead_q),
        .act_len    (act_q),
        .async_mode (mode_q == RDY_ASYNC),
        .strobe_now (strobe_now),
        .window     (window)
    );

    // Completion when the window is open and evaluated ready is high.
    always_comb complete = window && rdy_eval;

    // Sequencer state, configuration latch and bus control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= RDY_SYNC;
            lead_q   <= LEAD_W'(1);
            act_q    <= ACT_W'(1);
            bus_addr <= '0;
            bus_cs_n <= 1'b1;
            bus_rd_n <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state    <= ST_ACCESS;
                        mode_q   <= rdy_mode_e'(ready_mode);
                        lead_q   <= lead_eff;
                        act_q    <= act_eff;
                        bus_addr <= addr;
                        bus_cs_n <= 1'b0;
                    end
                end
                ST_ACCESS: begin
                    if (complete) begin
                        state    <= ST_IDLE;
                        bus_cs_n <= 1'b1;
                        bus_rd_n <= 1'b1;
                    end else if (strobe_now) begin
                        bus_rd_n <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read data capture and done pulse on the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= complete;
            if (complete) rdata <= bus_data;
        end
    end

    // The strobe is never low while chip-select is high (R6).
    assert_rd_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> bus_rd_n);

    // done lasts a single cycle (R6).
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A strobe release always comes with done (R6).
    assert_rd_rise_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> done);

    // busy drops only on a completion (R6).
    assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // The address changes only when a request is accepted (R7).
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_IDLE && req) |=> $stable(bus_addr));

    // No acceptance on the completing edge: one idle cycle minimum (R9).
    assert_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_cs_n);
endmodule

// File: tb/sim_xbus_rd_seq.sv
// Bench for the external bus read sequencer: behavioural model compared on
// every cycle, plus directed timing measurements.
module sim_xbus_rd_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ready_mode = 1'b0;
    logic [1:0]    lead_cnt = 2'd1;
    logic [2:0]    active_cnt = 3'd1;
    logic          busy, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_rd_n;
    logic [DW-1:0] bus_data = '0;
    logic          bus_ready = 1'b1;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xbus_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
        .ready_mode(ready_mode), .lead_cnt(lead_cnt), .active_cnt(active_cnt),
        .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_data(bus_data),
        .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model state
    bit          m_busy, m_cs_n, m_rd_n, m_done;
    int          m_addr, m_rdata;
    int          mk, mL, mA;
    bit          m_async;
    bit          hist0, hist1;
    bit          armed = 1'b0;

    // Model: advance one bus cycle at each rising edge from the inputs.
    always @(posedge clk) begin
        bit nd;
        bit seen;
        int first;
        if (!rst_n) begin
            m_busy = 0; m_cs_n = 1; m_rd_n = 1; m_done = 0;
            m_addr = 0; m_rdata = 0; mk = 0; hist0 = 0; hist1 = 0;
            armed = 1'b1;
        end else begin
            nd = 0;
            if (!m_busy) begin
                if (req) begin
                    m_busy = 1; m_cs_n = 0; m_rd_n = 1; m_addr = int'(addr);
                    mL = (lead_cnt == 0) ? 1 : int'(lead_cnt);
                    mA = (active_cnt == 0) ? 1 : int'(active_cnt);
                    m_async = ready_mode; mk = 1;
                end
            end else begin
                seen  = m_async ? hist1 : hist0;
                first = m_async ? (mL + mA) : (mL + mA + 1);
                if (mk >= first && seen) begin
                    m_busy = 0; m_cs_n = 1; m_rd_n = 1;
                    m_rdata = int'(bus_data); nd = 1;
                end else begin
                    if (mk == mL) m_rd_n = 0;
                    mk++;
                end
            end
            m_done = nd;
            hist1 = hist0;
            hist0 = bus_ready;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (armed && !finished) begin
            chk(bus_cs_n == m_cs_n, "R2 cs_n", int'(bus_cs_n), int'(m_cs_n));
            chk(bus_rd_n == m_rd_n, "R3 rd_n", int'(bus_rd_n), int'(m_rd_n));
            chk(done == m_done, "R6 done", int'(done), int'(m_done));
            chk(int'(rdata) == m_rdata, "R10 rdata", int'(rdata), m_rdata);
            chk(int'(bus_addr) == m_addr, "R7 bus_addr", int'(bus_addr), m_addr);
            chk(busy == m_busy, "R9 busy", int'(busy), int'(m_busy));
        end
    end

    // One access: ready goes high from access cycle rdy_at on.
    task automatic run_acc(input int l, input int a, input bit md, input int ad,
                           input int rdy_at, input int exp_len, input int exp_rd,
                           input string tag);
        int c = 0;
        int rd_first = 0;
        @(negedge clk);
        bus_ready = (rdy_at <= 0);
        req = 1; addr = AW'(ad); lead_cnt = 2'(l); active_cnt = 3'(a); ready_mode = md;
        @(negedge clk);
        req = 0;
        chk(bus_cs_n == 0 && busy == 1 && int'(bus_addr) == ad, "R2 accept", int'(bus_addr), ad);
        while (!bus_cs_n && c < 100) begin
            c++;
            if (!bus_rd_n && rd_first == 0) rd_first = c;
            bus_ready = (c >= rdy_at);
            bus_data  = DW'(16'hA500 ^ (c * 16'h0111) ^ ad);
            @(negedge clk);
        end
        chk(c == exp_len, {tag, " access length"}, c, exp_len);
        chk(rd_first == exp_rd, "R3 strobe start", rd_first, exp_rd);
        chk(done == 1, "R6 done after completion", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(int'(bus_addr) == ad, "R7 address held idle", int'(bus_addr), ad);
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        chk(bus_cs_n == 1 && bus_rd_n == 1 && busy == 0 && done == 0, "R1 reset ctrl", int'(bus_cs_n), 1);
        chk(bus_addr == 0 && rdata == 0, "R1 reset data", int'(bus_addr), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(bus_cs_n == 1 && busy == 0, "R1 after release", int'(busy), 0);

        run_acc(2, 3, 0, 16'h1234, 0, 6, 3, "R4 sync");
        run_acc(2, 3, 1, 16'h2345, 0, 5, 3, "R5 async");
        run_acc(1, 2, 0, 16'h3456, 7, 8, 2, "R4 sync stretched");
        run_acc(1, 2, 1, 16'h4567, 7, 9, 2, "R5 async stretched");
        run_acc(2, 2, 1, 16'h5678, 3, 5, 3, "R5 async second sample");
        run_acc(2, 2, 0, 16'h6789, 5, 6, 3, "R4 sync second sample");
        run_acc(0, 0, 0, 16'h789A, 0, 3, 2, "R8 zero sync");
        run_acc(0, 0, 1, 16'h89AB, 0, 2, 2, "R8 zero async");
        run_acc(3, 7, 0, 16'h9ABC, 0, 11, 4, "R4 max sync");
        run_acc(3, 7, 1, 16'hABCD, 0, 10, 4, "R5 max async");

        // Held request: addr change mid-access ignored, one idle cycle between.
        @(negedge clk);
        bus_ready = 1; req = 1; addr = 16'hC0DE; lead_cnt = 1; active_cnt = 1; ready_mode = 0;
        @(negedge clk);
        @(negedge clk);
        addr = 16'hBEEF;
        chk(int'(bus_addr) == 16'hC0DE, "R9 addr ignored in access", int'(bus_addr), 16'hC0DE);
        while (!bus_cs_n) @(negedge clk);
        gap = 0;
        while (bus_cs_n && gap < 20) begin gap++; @(negedge clk); end
        chk(gap == 1, "R9 idle gap", gap, 1);
        chk(int'(bus_addr) == 16'hBEEF, "R9 second address", int'(bus_addr), 16'hBEEF);
        req = 0;
        while (!bus_cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(int'(rdata) == m_rdata, "R10 rdata held", int'(rdata), m_rdata);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule